// File: doc/BRIEF.md
# Software-Triggered Interrupt Message Generator

This block is a bus-slave peripheral that lets any bus master raise an interrupt by software alone. A master writes a 32-bit word to the trigger register. The block holds that word and asks the response-bus arbiter for a slot. In the first cycle in which the arbiter grants a slot, the block places the word on the shared slave response bus as an interrupt message. A single flag bit marks the message as an interrupt. Its layout matches a message raised by a hardware peripheral, so the interrupt controller handles both kinds in the same way.

The register side has a trigger register and a status register. The status register reports whether a message is still waiting and whether a trigger write was lost. Only one message can wait at a time. A trigger write that arrives while one is pending is dropped and sets a sticky overrun flag, which the next status read clears.

The control is a two-state machine. In `ST_IDLE` no message is held. The transition `accept` (a trigger write in `ST_IDLE`) moves it to `ST_ARMED`. In `ST_ARMED` the request to the arbiter is raised. The transition `issue` (grant seen in `ST_ARMED`) drives the message in that same cycle and returns the machine to `ST_IDLE`. Every other input keeps the machine in its current state.

Top module: `swi_msg_gen`

## Requirements
- R1: A write to the trigger address (default 0x00) while idle stores the written word, and from the next cycle `rsp_req` is high.
- R2: The message is driven only in a cycle in which `rsp_gnt` is high while the block is armed. In that cycle `rsp_valid` and `rsp_irq` are both 1, and in every other cycle both are 0 and `rsp_data` is 0.
- R3: Payload layout: bits [11:0] carry the vector number, bits [17:12] the target controller number, and bits [31:18] pass through unchanged. The driven payload therefore equals the written word.
- R4: `rsp_req` stays high until a grant arrives, and it is low in the cycle after the message was driven.
- R5: A trigger write while a message is pending has no effect on the pending message, and it sets the sticky overrun flag.
- R6: A read of the status address (default 0x04) returns bit 0 = busy (a message is pending) and bit 1 = overrun, with all other bits 0. Such a read clears the overrun flag, unless a new overrun is set in the same cycle.
- R7: Writes to any address other than the trigger address change nothing. Reads of any address other than the status address return 0.
- R8: Every request is acknowledged by `reg_ack` exactly one cycle later, and read data is valid in that same cycle.
- R9: After reset, `rsp_req`, `rsp_valid`, `reg_ack` and the overrun flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_ack | output | 1 | Access acknowledge, one cycle after request |
| reg_rdata | output | 32 | Read data, valid with reg_ack |
| rsp_gnt | input | 1 | Response-bus slot granted this cycle |
| rsp_req | output | 1 | Request for a response-bus slot |
| rsp_valid | output | 1 | Message present on the response bus |
| rsp_irq | output | 1 | Interrupt-type flag of the response word |
| rsp_data | output | 32 | Interrupt message payload |

## Verification
The assertions assume that a register request lasts a single cycle and that the arbiter grants only while `rsp_req` is high. Under that assumption, a request is always followed by an acknowledge, and a grant always results in a message. The bench drives every access as a one-cycle pulse on the falling edge. It raises `rsp_gnt` only after it has seen the request, and it lowers the grant before the next edge after the message is issued. Grant delays from zero to several cycles are covered, so the wait in `ST_ARMED` is exercised at different lengths.

// File: rtl/swi_msg_pkg.sv
package swi_msg_pkg;

    localparam int MSG_W  = 32;
    localparam int VEC_W  = 12;
    localparam int TGT_W  = 6;
    localparam int PASS_W = MSG_W - VEC_W - TGT_W;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_OVR_BIT  = 1;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } swi_state_e;

    typedef struct packed {
        logic [PASS_W-1:0] extra;
        logic [TGT_W-1:0]  target;
        logic [VEC_W-1:0]  vector;
    } swi_msg_t;

endpackage

// File: rtl/swi_reg_port.sv
module swi_reg_port
    import swi_msg_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 'h00,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              busy,
    input  logic              overrun,
    output logic              trig_wr,
    output logic              stat_rd,
    output logic              reg_ack,
    output logic [MSG_W-1:0]  reg_rdata
);

    logic [MSG_W-1:0] stat_word;

    always_comb begin
        trig_wr = reg_req && reg_we && (reg_addr == TRIG_ADDR);
        stat_rd = reg_req && !reg_we && (reg_addr == STAT_ADDR);
    end

    always_comb begin
        stat_word = '0;
        stat_word[STAT_BUSY_BIT] = busy;
        stat_word[STAT_OVR_BIT]  = overrun;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_ack   <= 1'b0;
            reg_rdata <= '0;
        end else begin
            reg_ack   <= reg_req;
            reg_rdata <= stat_rd ? stat_word : '0;
        end
    end

endmodule

// File: rtl/swi_msg_format.sv
module swi_msg_format
    import swi_msg_pkg::*;
(
    input  logic [MSG_W-1:0] word_in,
    output swi_msg_t         msg_out
);

    always_comb begin
        msg_out.vector = word_in[VEC_W-1:0];
        msg_out.target = word_in[VEC_W+TGT_W-1:VEC_W];
        msg_out.extra  = word_in[MSG_W-1:VEC_W+TGT_W];
    end

endmodule

// File: rtl/swi_issue_fsm.sv
module swi_issue_fsm
    import swi_msg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_wr,
    input  logic             stat_rd,
    input  swi_msg_t         msg_in,
    input  logic             rsp_gnt,
    output logic             busy,
    output logic             overrun,
    output logic             rsp_req,
    output logic             rsp_valid,
    output logic             rsp_irq,
    output logic [MSG_W-1:0] rsp_data
);

    swi_state_e state_q, state_d;
    swi_msg_t   msg_q;
    logic       ovr_q, ovr_d;
    logic       accept, issue;

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        issue   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_wr) begin
                    accept  = 1'b1;
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (rsp_gnt) begin
                    issue   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        if (trig_wr && (state_q != ST_IDLE)) begin
            ovr_d = 1'b1;
        end else if (stat_rd) begin
            ovr_d = 1'b0;
        end else begin
            ovr_d = ovr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            msg_q   <= '0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ovr_q   <= ovr_d;
            if (accept) begin
                msg_q <= msg_in;
            end
        end
    end

    always_comb begin
        busy      = (state_q == ST_ARMED);
        overrun   = ovr_q;
        rsp_req   = busy;
        rsp_valid = issue;
        rsp_irq   = issue;
        rsp_data  = issue ? msg_q : '0;
    end

endmodule

// File: rtl/swi_msg_gen.sv
module swi_msg_gen
    import swi_msg_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 'h00,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              reg_ack,
    output logic [31:0]       reg_rdata,
    input  logic              rsp_gnt,
    output logic              rsp_req,
    output logic              rsp_valid,
    output logic              rsp_irq,
    output logic [31:0]       rsp_data
);

    logic     trig_wr, stat_rd, busy, overrun;
    swi_msg_t fmt_msg;

    swi_reg_port #(
        .ADDR_W   (ADDR_W),
        .TRIG_ADDR(TRIG_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) port_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_req  (reg_req),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .busy     (busy),
        .overrun  (overrun),
        .trig_wr  (trig_wr),
        .stat_rd  (stat_rd),
        .reg_ack  (reg_ack),
        .reg_rdata(reg_rdata)
    );

    swi_msg_format fmt_i (
        .word_in(reg_wdata),
        .msg_out(fmt_msg)
    );

    swi_issue_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_wr  (trig_wr),
        .stat_rd  (stat_rd),
        .msg_in   (fmt_msg),
        .rsp_gnt  (rsp_gnt),
        .busy     (busy),
        .overrun  (overrun),
        .rsp_req  (rsp_req),
        .rsp_valid(rsp_valid),
        .rsp_irq  (rsp_irq),
        .rsp_data (rsp_data)
    );

endmodule

// File: rtl/swi_msg_gen_chk.sv
module swi_msg_gen_chk #(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_ack,
    input logic [31:0]       reg_rdata,
    input logic              rsp_gnt,
    input logic              rsp_req,
    input logic              rsp_valid,
    input logic              rsp_irq
);

    // R2
    valid_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_gnt && rsp_req));

    // R2
    irq_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_irq == rsp_valid);

    // R1
    trigger_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && (reg_addr == TRIG_ADDR) && !rsp_req) |=> rsp_req);

    // R4
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_req && !rsp_gnt) |=> rsp_req);

    // R4
    req_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_req);

    // R8
    ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> reg_ack);

    // R6
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ack |-> (reg_rdata[31:2] == '0));

endmodule

bind swi_msg_gen swi_msg_gen_chk #(
    .ADDR_W   (ADDR_W),
    .TRIG_ADDR(TRIG_ADDR)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_req  (reg_req),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_ack  (reg_ack),
    .reg_rdata(reg_rdata),
    .rsp_gnt  (rsp_gnt),
    .rsp_req  (rsp_req),
    .rsp_valid(rsp_valid),
    .rsp_irq  (rsp_irq)
);

// File: tb/swi_msg_gen_tb.sv
`timescale 1ns/1ps
module swi_msg_gen_tb_top;

    localparam logic [7:0] TRIG = 8'h00;
    localparam logic [7:0] STAT = 8'h04;
    localparam logic [7:0] OTHR = 8'h08;

    // {word, grant delay}
    localparam logic [39:0] VECS [6] = '{
        {32'h0000_0001, 8'd0},
        {32'h0003_F000, 8'd1},
        {32'hFFFC_0000, 8'd3},
        {32'hDEAD_BEEF, 8'd2},
        {32'h0001_2FFF, 8'd5},
        {32'h8004_5A5A, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_ack;
    logic [31:0] reg_rdata;
    logic        rsp_gnt = 1'b0;
    logic        rsp_req, rsp_valid, rsp_irq;
    logic [31:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    swi_msg_gen dut_i (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
        .reg_rdata(reg_rdata), .rsp_gnt(rsp_gnt), .rsp_req(rsp_req),
        .rsp_valid(rsp_valid), .rsp_irq(rsp_irq), .rsp_data(rsp_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
        check("R8 write ack", {31'd0, reg_ack}, 32'd1);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_req = 1'b0;
        check("R8 read ack", {31'd0, reg_ack}, 32'd1);
        d = reg_rdata;
    endtask

    // raise grant at a falling edge, check issue, drop it next falling edge
    task automatic grant_and_check(input logic [31:0] exp);
        rsp_gnt = 1'b1;
        #1;
        check("R2 valid with grant", {31'd0, rsp_valid}, 32'd1);
        check("R2 irq flag", {31'd0, rsp_irq}, 32'd1);
        check("R3 payload", rsp_data, {exp[31:18], exp[17:12], exp[11:0]});
        @(negedge clk);
        rsp_gnt = 1'b0;
        #1;
        check("R4 req low after issue", {31'd0, rsp_req}, 32'd0);
        check("R2 no valid when idle", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 rsp_req", {31'd0, rsp_req}, 32'd0);
        check("R9 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R9 reg_ack", {31'd0, reg_ack}, 32'd0);
        rst_n = 1'b1;
        do_read(STAT, rd);
        check("R9 status after reset", rd, 32'd0);

        // table walk: R1 R2 R3 R4
        foreach (VECS[i]) begin
            logic [31:0] w = VECS[i][39:8];
            int dly = int'(VECS[i][7:0]);
            do_write(TRIG, w);
            check("R1 req raised", {31'd0, rsp_req}, 32'd1);
            for (int k = 0; k < dly; k++) begin
                check("R2 no valid without grant", {31'd0, rsp_valid}, 32'd0);
                check("R2 data zero without grant", rsp_data, 32'd0);
                @(negedge clk);
                check("R4 req held", {31'd0, rsp_req}, 32'd1);
            end
            grant_and_check(w);
        end

        // R5 overrun: second write while armed
        do_write(TRIG, 32'h1234_5678);
        do_write(TRIG, 32'hAAAA_5555);
        do_read(STAT, rd);
        check("R6 status busy+overrun", rd, 32'h3);
        // R7 write to status does not clear overrun... already cleared by read; reread shows busy only
        do_read(STAT, rd);
        check("R6 overrun cleared by read", rd, 32'h1);
        @(negedge clk);
        grant_and_check(32'h1234_5678); // R5 first word kept
        do_read(STAT, rd);
        check("R6 status idle", rd, 32'd0);

        // R7 write to other address: nothing starts
        do_write(OTHR, 32'hFFFF_FFFF);
        #1;
        check("R7 other write no req", {31'd0, rsp_req}, 32'd0);
        do_read(OTHR, rd);
        check("R7 other read zero", rd, 32'd0);
        do_read(TRIG, rd);
        check("R7 trigger read zero", rd, 32'd0);

        // R7 write to status does not clear a set overrun
        do_write(TRIG, 32'h0000_0ABC);
        do_write(TRIG, 32'h0000_0DEF);
        do_write(STAT, 32'h0);
        do_read(STAT, rd);
        check("R7 status write ignored", rd, 32'h3);
        @(negedge clk);
        grant_and_check(32'h0000_0ABC);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule